// File: doc/BRIEF.md
# Receive Bit FIFO with Serial Burst Readout

This block buffers received data one bit at a time and lets a host drain it over a four-wire serial link. A demodulator upstream pushes single bits through a write strobe. The host lowers chip select, shifts in an 8-bit read instruction on the data-in line, and then clocks out a fixed burst of 32 data slots followed by an 8-bit status trailer. The trailer reports how many of the 32 slots carry real data and whether the buffer has lost bits to overflow. The read position moves on only by the number of valid bits just reported, so any bits left over stay queued for the next burst.

The buffer can be emptied by several external events. A frame-start strobe empties it when the buffer has overflowed, or when frame-start emptying is enabled and the lock input is low. A cycle-start strobe empties it when cycle-start emptying is enabled. The serial pins are sampled in the system clock domain and are assumed to be synchronous to `clk`. Each serial clock phase must last at least two system clocks. The host samples on the rising serial clock edge, and the block updates its output on the falling edge.

Top module: `rx_bit_fifo_spi`

## Requirements
- R1: After reset the buffer is empty, the overflow flag is clear, and `spi_miso_oe` and `spi_miso` are both 0.
- R2: `spi_miso_oe` is 0 whenever chip select is high and during the eight instruction bits, which are received MSB first. If the instruction differs from parameter `READ_OP`, `spi_miso_oe` stays 0 for the rest of the selection.
- R3: After a matching instruction, 48-bit frames carry data slots D0..D31, oldest bit first, then status bits S7 down to S0. A slot at or beyond the valid count is driven 0.
- R4: Status bits S5..S0 hold min(fill, 32), where fill is sampled at the eighth rising serial clock edge. Bit S6 is always 0.
- R5: When chip select rises after all 48 rising edges of a matching burst with no overflow, the read position advances by exactly the reported count. Unreported bits remain queued in order.
- R6: A bit written while the buffer holds 256 bits is dropped and sets overflow, reported as S7 = 1. Filling to exactly 256 bits does not set it. The flag holds until an emptying event or reset.
- R7: In a burst whose overflow snapshot is set, all 32 data slots and S5..S0 are driven 0, and the read position does not move.
- R8: A frame-start strobe while overflow is set empties the buffer and clears overflow, regardless of the enable and lock inputs.
- R9: With overflow clear, a frame-start strobe empties the buffer only if `fs_init_en` is 1 and `fifo_lock` is 0.
- R10: A cycle-start strobe empties the buffer when `cs_init_en` is 1 and has no effect when it is 0.
- R11: Emptying resets both positions and clears overflow. A write in the same cycle is discarded, and an emptying event during a burst cancels that burst's read advance.
- R12: A burst that ends before its 48th rising edge does not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one received bit |
| wr_bit | input | 1 | Received bit value |
| frame_start | input | 1 | One-cycle frame-start event |
| cycle_start | input | 1 | One-cycle run-mode entry event |
| fs_init_en | input | 1 | Enables emptying on frame start |
| cs_init_en | input | 1 | Enables emptying on cycle start |
| fifo_lock | input | 1 | Blocks enabled frame-start emptying |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |

## Verification
The hardest state to reach from the ports is the overflow corner. The buffer must first be filled to exactly 256 bits to show that no flag is raised there. A 32-bit read then makes room, and exactly one write past the refilled limit pushes the buffer into overflow. A second read then shows that the flag and the data suppression persist and that no bits were consumed. An emptying event then has to clear the flag with the enable and lock inputs set so that only the overflow rule can trigger it. The stimulus builds this step by step against a bit-queue model of the buffer. Each burst's expected frame goes into a scoreboard queue, and a monitor compares it with the output edge by edge.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
    localparam int INSTR_BITS  = 8;
    localparam int DATA_BITS   = 32;
    localparam int STATUS_BITS = 8;
    localparam int FRAME_BITS  = INSTR_BITS + DATA_BITS + STATUS_BITS;
    localparam int CNT_W       = $clog2(DATA_BITS + 1);
    localparam int IDX_W       = $clog2(DATA_BITS);
    localparam int POS_W       = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/bitfifo_store.sv
module bitfifo_store
    import rxfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int FW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             init,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_cnt,
    input  logic [IDX_W-1:0] peek_idx,
    output logic             peek_bit,
    output logic [FW-1:0]    fill,
    output logic             ovf
);
    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [FW-1:0]    fill;
        logic             ovf;
    } store_t;

    store_t s_d, s_q;
    logic   accept;

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        if (init) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.fill = '0;
            s_d.ovf  = 1'b0;
        end else begin
            if (wr_en) begin
                if (s_q.fill == FW'(DEPTH)) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.mem[s_q.wptr] = wr_bit;
                    s_d.wptr          = s_q.wptr + 1'b1;
                    accept            = 1'b1;
                end
            end
            if (commit) begin
                s_d.rptr = s_q.rptr + AW'(commit_cnt);
            end
            s_d.fill = s_q.fill + FW'(accept) - (commit ? FW'(commit_cnt) : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign peek_bit = s_q.mem[s_q.rptr + AW'(peek_idx)];
    assign fill     = s_q.fill;
    assign ovf      = s_q.ovf;

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill <= FW'(DEPTH));
    assert_full_write_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !init && fill == FW'(DEPTH)) |=> ovf);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !init) |=> ovf);
    assert_init_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (fill == '0 && !ovf));
    assert_commit_within_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (FW'(commit_cnt) <= fill));
endmodule

// File: rtl/rx_init_ctrl.sv
module rx_init_ctrl (
    input  logic frame_start,
    input  logic cycle_start,
    input  logic fs_init_en,
    input  logic cs_init_en,
    input  logic fifo_lock,
    input  logic ovf,
    output logic init
);
    logic fs_hit, cs_hit;

    always_comb begin
        fs_hit = frame_start && (ovf || (fs_init_en && !fifo_lock));
        cs_hit = cycle_start && cs_init_en;
        init   = fs_hit || cs_hit;
    end
endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader
    import rxfifo_pkg::*;
#(
    parameter logic [INSTR_BITS-1:0] READ_OP = 8'h6C,
    parameter int FILL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_csn,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    input  logic [FILL_W-1:0] fill,
    input  logic             ovf,
    input  logic             peek_bit,
    input  logic             init,
    output logic [IDX_W-1:0] peek_idx,
    output logic             commit,
    output logic [CNT_W-1:0] commit_cnt,
    output logic             spi_miso,
    output logic             spi_miso_oe
);
    localparam logic [POS_W-1:0] POS_DATA = POS_W'(INSTR_BITS);
    localparam logic [POS_W-1:0] POS_STAT = POS_W'(INSTR_BITS + DATA_BITS);
    localparam logic [POS_W-1:0] POS_END  = POS_W'(FRAME_BITS);

    typedef struct packed {
        logic                  sclk;
        logic [POS_W-1:0]      pos;
        logic [INSTR_BITS-1:0] instr;
        logic                  match;
        logic [CNT_W-1:0]      cnt;
        logic                  sovf;
        logic                  pending;
        logic                  out;
        logic                  oe;
    } rd_t;

    rd_t r_d, r_q;
    logic                   rise, fall;
    logic [INSTR_BITS-1:0]  instr_nx;
    logic [STATUS_BITS-1:0] status_w;
    logic [POS_W-1:0]       stat_sel;
    logic                   sel_bit;

    assign peek_idx   = IDX_W'(r_q.pos - POS_DATA);
    assign status_w   = {r_q.sovf, 1'b0, (r_q.sovf ? CNT_W'(0) : r_q.cnt)};
    assign stat_sel   = POS_END - 1'b1 - r_q.pos;
    assign commit_cnt = r_q.cnt;
    assign commit     = spi_csn && r_q.pending && (r_q.pos == POS_END) && !init;

    always_comb begin
        if (r_q.pos < POS_DATA) begin
            sel_bit = 1'b0;
        end else if (r_q.pos < POS_STAT) begin
            sel_bit = !r_q.sovf && ({1'b0, peek_idx} < r_q.cnt) && peek_bit;
        end else if (r_q.pos < POS_END) begin
            sel_bit = status_w[stat_sel[$clog2(STATUS_BITS)-1:0]];
        end else begin
            sel_bit = 1'b0;
        end
    end

    always_comb begin
        r_d      = r_q;
        rise     = spi_sclk && !r_q.sclk;
        fall     = !spi_sclk && r_q.sclk;
        instr_nx = {r_q.instr[INSTR_BITS-2:0], spi_mosi};
        r_d.sclk = spi_sclk;
        if (spi_csn) begin
            r_d.pos     = '0;
            r_d.instr   = '0;
            r_d.match   = 1'b0;
            r_d.pending = 1'b0;
            r_d.out     = 1'b0;
            r_d.oe      = 1'b0;
        end else begin
            if (rise && r_q.pos < POS_END) begin
                r_d.pos = r_q.pos + 1'b1;
                if (r_q.pos < POS_DATA) begin
                    r_d.instr = instr_nx;
                end
                if (r_q.pos == POS_DATA - 1'b1 && instr_nx == READ_OP) begin
                    r_d.match   = 1'b1;
                    r_d.sovf    = ovf;
                    r_d.pending = !ovf;
                    r_d.cnt     = (fill >= FILL_W'(DATA_BITS)) ? CNT_W'(DATA_BITS)
                                                                : CNT_W'(fill);
                end
            end
            if (fall) begin
                r_d.out = sel_bit;
                r_d.oe  = r_q.match && (r_q.pos >= POS_DATA);
            end
            if (init) begin
                r_d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign spi_miso    = r_q.out;
    assign spi_miso_oe = r_q.oe;

    assert_hiz_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |=> !spi_miso_oe);
    assert_hiz_instruction_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_csn && r_q.pos < POS_DATA) |-> !spi_miso_oe);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(DATA_BITS));
    assert_s6_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && !r_q.sclk && r_q.pos == POS_STAT + 1'b1) |-> !spi_miso);
    assert_ovf_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && r_q.sovf && !r_q.sclk && r_q.pos >= POS_DATA
         && r_q.pos < POS_STAT) |-> !spi_miso);
endmodule

// File: rtl/rx_bit_fifo_spi.sv
module rx_bit_fifo_spi
    import rxfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter logic [INSTR_BITS-1:0] READ_OP = 8'h6C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic frame_start,
    input  logic cycle_start,
    input  logic fs_init_en,
    input  logic cs_init_en,
    input  logic fifo_lock,
    input  logic spi_csn,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int FW = $clog2(DEPTH) + 1;

    logic             init, commit, peek_bit, ovf;
    logic [CNT_W-1:0] commit_cnt;
    logic [IDX_W-1:0] peek_idx;
    logic [FW-1:0]    fill;

    rx_init_ctrl u_init (
        .frame_start (frame_start),
        .cycle_start (cycle_start),
        .fs_init_en  (fs_init_en),
        .cs_init_en  (cs_init_en),
        .fifo_lock   (fifo_lock),
        .ovf         (ovf),
        .init        (init)
    );

    bitfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_bit     (wr_bit),
        .init       (init),
        .commit     (commit),
        .commit_cnt (commit_cnt),
        .peek_idx   (peek_idx),
        .peek_bit   (peek_bit),
        .fill       (fill),
        .ovf        (ovf)
    );

    spi_burst_reader #(.READ_OP(READ_OP), .FILL_W(FW)) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_csn     (spi_csn),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi),
        .fill        (fill),
        .ovf         (ovf),
        .peek_bit    (peek_bit),
        .init        (init),
        .peek_idx    (peek_idx),
        .commit      (commit),
        .commit_cnt  (commit_cnt),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    assert_frame_start_clears_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && ovf) |=> (!ovf && fill == '0));
    assert_cycle_start_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && cs_init_en) |=> (fill == '0));
    assert_locked_frame_start_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && fifo_lock && !ovf && !cycle_start && !wr_en && !commit)
        |=> $stable(fill));
endmodule

// File: tb/rx_bit_fifo_spi_tb.sv
module rx_bit_fifo_spi_tb;
    localparam logic [7:0] OP = 8'h6C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_bit = 1'b0;
    logic frame_start = 1'b0, cycle_start = 1'b0;
    logic fs_init_en = 1'b0, cs_init_en = 1'b0, fifo_lock = 1'b0;
    logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;

    int checks = 0;
    int fails  = 0;

    bit    model_q[$];
    bit    model_ovf = 1'b0;
    bit    exp_oe[$];
    bit    exp_val[$];
    bit    exp_chk[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;

    rx_bit_fifo_spi #(.DEPTH(256), .READ_OP(OP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
        .frame_start(frame_start), .cycle_start(cycle_start),
        .fs_init_en(fs_init_en), .cs_init_en(cs_init_en), .fifo_lock(fifo_lock),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compares each rising serial edge against the scoreboard queue
    always @(posedge spi_sclk) begin
        if (exp_oe.size() > 0) begin
            automatic bit    e_oe  = exp_oe.pop_front();
            automatic bit    e_v   = exp_val.pop_front();
            automatic bit    e_c   = exp_chk.pop_front();
            automatic string e_tag = exp_tag.pop_front();
            check({e_tag, " oe"}, spi_miso_oe, e_oe);
            if (e_c) check({e_tag, " bit"}, spi_miso, e_v);
        end
    end

    task automatic push(input bit oe, input bit v, input bit c, input string tag);
        exp_oe.push_back(oe); exp_val.push_back(v);
        exp_chk.push_back(c); exp_tag.push_back(tag);
    endtask

    task automatic model_init();
        model_q.delete();
        model_ovf = 1'b0;
    endtask

    task automatic write_bits(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            automatic bit b = ((i * 7 + seed) % 5) < 2;
            @(negedge clk);
            wr_en = 1'b1; wr_bit = b;
            if (model_q.size() == 256) model_ovf = 1'b1;
            else model_q.push_back(b);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input bit fs, input bit cs);
        @(negedge clk);
        frame_start = fs; cycle_start = cs;
        if ((fs && (model_ovf || (fs_init_en && !fifo_lock))) || (cs && cs_init_en))
            model_init();
        @(negedge clk);
        frame_start = 1'b0; cycle_start = 1'b0;
    endtask

    task automatic spi_read(input logic [7:0] op, input int nrise);
        automatic bit match = (op == OP);
        automatic int cnt   = (model_q.size() > 32) ? 32 : model_q.size();
        automatic bit sovf  = model_ovf;
        automatic logic [7:0] st = {sovf, 1'b0, sovf ? 6'd0 : 6'(cnt)};
        for (int i = 0; i < nrise; i++) begin
            if (i < 8 || !match) push(1'b0, 1'b0, 1'b0, "R2");
            else if (i < 40) begin
                automatic int k = i - 8;
                automatic bit v = (!sovf && k < cnt) ? model_q[k] : 1'b0;
                push(1'b1, v, 1'b1, sovf ? "R7" : "R3");
            end else begin
                automatic int j = 7 - (i - 40);
                push(1'b1, st[j], 1'b1, (j == 7) ? "R6" : (sovf ? "R7" : "R4"));
            end
        end
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nrise; i++) begin
            spi_mosi = (i < 8) ? op[7 - i] : 1'b0;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_csn = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 deselected oe", spi_miso_oe, 1'b0);
        if (match && nrise == 48 && !sovf)
            for (int i = 0; i < cnt; i++) void'(model_q.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset oe", spi_miso_oe, 1'b0);
        check("R1 reset miso", spi_miso, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        spi_read(OP, 48);                        // R1 empty: count 0
        write_bits(10, 1); spi_read(OP, 48);     // R3 R4 partial burst
        spi_read(OP, 48);                        // R5 drained
        write_bits(40, 3); spi_read(OP, 48);     // R4 saturates at 32
        spi_read(OP, 48);                        // R5 remaining 8 in order
        write_bits(5, 2); spi_read(OP, 20);      // R12 aborted burst
        spi_read(OP, 48);
        write_bits(3, 4); spi_read(8'h93, 48);   // R2 wrong opcode
        spi_read(OP, 48);
        write_bits(4, 0); strobe(1'b0, 1'b1);    // R10 disabled: no effect
        write_bits(1, 1); spi_read(OP, 48);
        cs_init_en = 1'b1;
        write_bits(6, 2); strobe(1'b0, 1'b1);    // R10 enabled: emptied
        spi_read(OP, 48);
        fs_init_en = 1'b1; fifo_lock = 1'b1;
        write_bits(7, 3); strobe(1'b1, 1'b0);    // R9 locked: kept
        spi_read(OP, 48);
        fifo_lock = 1'b0;
        write_bits(7, 1); strobe(1'b1, 1'b0);    // R9 unlocked: emptied
        spi_read(OP, 48);
        fs_init_en = 1'b0;
        write_bits(7, 2); strobe(1'b1, 1'b0);    // R9 disabled: kept
        spi_read(OP, 48);
        // R11: write coincides with emptying event
        write_bits(3, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_bit = 1'b1; cycle_start = 1'b1;
        model_init();
        @(negedge clk);
        wr_en = 1'b0; cycle_start = 1'b0;
        spi_read(OP, 48);
        // R6 boundary and overflow, R7 suppression, R8 clear
        write_bits(256, 5); spi_read(OP, 48);    // full, no overflow
        write_bits(33, 6); spi_read(OP, 48);     // one write too many
        spi_read(OP, 48);                        // sticky, not consumed
        cs_init_en = 1'b0; fs_init_en = 1'b0; fifo_lock = 1'b1;
        strobe(1'b1, 1'b0);                      // R8 overflow forces init
        spi_read(OP, 48);
        write_bits(9, 2); spi_read(OP, 48);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule